// File: doc/BRIEF.md
# Directory Sharing-Class Tracker

This block sits beside a coherence directory. It records, for every tracked cache block, how that block has been shared among the cores so far. Each core reports its accesses as a request that carries the core number, the block's table index and a read/write flag. For each request the tracker returns the block's class after the access, and a flag that says whether an access of that class may be reordered freely. Blocks are tracked one by one at cache-block granularity in a direct-indexed table. Loads and stores use the same request port. Whether the request came as an explicit store request or rode on a load's coherence message does not matter here.

A block seen by a single core is private. A block that several cores have touched but nobody has written since it became shared is shared read-only. A block that has been written while shared is shared read-write. The first two classes are safe and the last one is unsafe. Classes only move toward the unsafe end until reset.

When an access would make a safe block unsafe, the tracker does not commit the change at once. It raises a downgrade request to every core except the one that caused it. It then waits for each of those cores to acknowledge, which each core does after draining its store buffer. Only then does it write the new class and answer the request that caused it. While that handshake is open, some requests are held off with a busy signal.

Top module: `share_class_dir`

## Requirements
- R1: After reset every entry is untracked, `rsp_valid` is 0 and `dg_req` is all zeros. The first access to an untracked entry makes it private (class code 2'b00, safe 1), with the requesting core recorded as owner.
- R2: Reads and writes by the owner of a private entry leave it private and safe.
- R3: A read by a core other than the owner of a private entry moves it to shared read-only (code 2'b01, safe 1). Reads by any core leave a shared read-only entry unchanged.
- R4: A write by a non-owner to a private entry, or any write to a shared read-only entry, moves it to shared read-write (code 2'b10, safe 0). `rsp_safe` is 1 exactly when the reported class is not 2'b10.
- R5: On such a move, starting one cycle after the request is accepted, `dg_req` has a 1 for every core except the requester, and `dg_idx` holds the entry index. Bit i of `dg_req` clears one cycle after `dg_ack[i]` is sampled high. A bit that is not pending ignores its acknowledgement.
- R6: The request that caused the move gets no response until all acknowledgements are in. Its response (class 2'b10, safe 0, the original core and index) appears one cycle after the last acknowledgement is sampled.
- R7: While a downgrade is open, `req_busy` is 1 for a request to the same entry and for a request that would itself start a downgrade. Other requests are accepted as usual.
- R8: In the cycle in which the last outstanding acknowledgement arrives, `req_busy` is 1 for every valid request.
- R9: A shared read-write entry stays shared read-write for every further access by any core, and starts no downgrade.
- R10: An accepted request that starts no downgrade is answered one cycle later with `rsp_valid` 1 and its core, index, new class and safe flag. A request seen with `req_busy` 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access notification present |
| req_core | input | CORE_W | Core issuing the access |
| req_idx | input | IDX_W | Table index of the block |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_busy | output | 1 | Request not taken this cycle; hold it |
| rsp_valid | output | 1 | Response present |
| rsp_core | output | CORE_W | Core of the answered request |
| rsp_idx | output | IDX_W | Index of the answered request |
| rsp_class | output | 2 | Class after the access |
| rsp_safe | output | 1 | 1 when the class permits relaxed ordering |
| dg_req | output | NUM_CORES | Per-core pending downgrade |
| dg_idx | output | IDX_W | Entry under downgrade |
| dg_ack | input | NUM_CORES | Per-core downgrade acknowledgement |

## Verification
Two things can happen in the same cycle: the handshake ends and a new request arrives for an unrelated entry. If both were accepted, two responses would compete for the single response register. The bench opens a downgrade and, while acknowledgements are still outstanding, sends unrelated requests that must go through and get answered. It then pairs the final acknowledgement with a fresh request. It expects busy in that cycle, the downgrade's response on the next edge, and the held request accepted one cycle later.

// File: rtl/sct_pkg.sv
package sct_pkg;

   typedef enum logic [1:0] {
      CLS_PRIV = 2'b00,
      CLS_SRO  = 2'b01,
      CLS_SRW  = 2'b10
   } sct_cls_e;

   function automatic logic cls_is_safe(input sct_cls_e c);
      return c != CLS_SRW;
   endfunction

endpackage

// File: rtl/sct_table.sv
module sct_table #(
   parameter int NUM_ENTRIES = 16,
   parameter int CORE_W      = 2,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [1:0]        rd_cls,
   output logic [CORE_W-1:0] rd_owner,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_cls,
   input  logic [CORE_W-1:0] wr_owner
);

   logic [NUM_ENTRIES-1:0] ent_valid;
   logic [1:0]             ent_cls   [NUM_ENTRIES];
   logic [CORE_W-1:0]      ent_owner [NUM_ENTRIES];

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_cls[e]   <= 2'b00;
            ent_owner[e] <= '0;
         end else if (sel) begin
            ent_valid[e] <= 1'b1;
            ent_cls[e]   <= wr_cls;
            ent_owner[e] <= wr_owner;
         end
      end
   end

   assign rd_valid = ent_valid[rd_idx];
   assign rd_cls   = ent_cls[rd_idx];
   assign rd_owner = ent_owner[rd_idx];

endmodule

// File: rtl/sct_classify.sv
module sct_classify
   import sct_pkg::*;
#(
   parameter int CORE_W = 2
) (
   input  logic              hit_valid,
   input  logic [1:0]        cur_cls,
   input  logic [CORE_W-1:0] cur_owner,
   input  logic [CORE_W-1:0] core,
   input  logic              write,
   output sct_cls_e          nxt_cls,
   output logic [CORE_W-1:0] nxt_owner,
   output logic              escalate
);

   sct_cls_e cur_e;
   assign cur_e = sct_cls_e'(cur_cls);

   always_comb begin
      nxt_cls   = cur_e;
      nxt_owner = cur_owner;
      escalate  = 1'b0;
      if (!hit_valid) begin
         nxt_cls   = CLS_PRIV;
         nxt_owner = core;
      end else begin
         unique case (cur_e)
            CLS_PRIV: begin
               if (core != cur_owner) begin
                  if (write) begin
                     nxt_cls  = CLS_SRW;
                     escalate = 1'b1;
                  end else begin
                     nxt_cls = CLS_SRO;
                  end
               end
            end
            CLS_SRO: begin
               if (write) begin
                  nxt_cls  = CLS_SRW;
                  escalate = 1'b1;
               end
            end
            default: nxt_cls = CLS_SRW;
         endcase
      end
   end

endmodule

// File: rtl/sct_dgctl.sv
module sct_dgctl #(
   parameter int NUM_CORES = 4,
   parameter int IDX_W     = 4,
   localparam int CORE_W   = $clog2(NUM_CORES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CORE_W-1:0]    start_core,
   input  logic [IDX_W-1:0]     start_idx,
   input  logic [NUM_CORES-1:0] ack,
   output logic [NUM_CORES-1:0] pend,
   output logic                 active,
   output logic                 finishing,
   output logic [IDX_W-1:0]     idx,
   output logic [CORE_W-1:0]    core
);

   logic [NUM_CORES-1:0] start_mask;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_mask
      assign start_mask[c] = (start_core != CORE_W'(c));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         idx  <= '0;
         core <= '0;
      end else if (start) begin
         pend <= start_mask;
         idx  <= start_idx;
         core <= start_core;
      end else begin
         pend <= pend & ~ack;
      end
   end

   assign active    = |pend;
   assign finishing = active && ((pend & ~ack) == '0);

endmodule

// File: rtl/share_class_dir.sv
module share_class_dir
   import sct_pkg::*;
#(
   parameter int NUM_CORES   = 4,
   parameter int NUM_ENTRIES = 16,
   localparam int CORE_W     = $clog2(NUM_CORES),
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [CORE_W-1:0]    req_core,
   input  logic [IDX_W-1:0]     req_idx,
   input  logic                 req_write,
   output logic                 req_busy,
   output logic                 rsp_valid,
   output logic [CORE_W-1:0]    rsp_core,
   output logic [IDX_W-1:0]     rsp_idx,
   output logic [1:0]           rsp_class,
   output logic                 rsp_safe,
   output logic [NUM_CORES-1:0] dg_req,
   output logic [IDX_W-1:0]     dg_idx,
   input  logic [NUM_CORES-1:0] dg_ack
);

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("share_class_dir: NUM_CORES must be at least 2");
   end
   if (NUM_ENTRIES < 2 || (NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("share_class_dir: NUM_ENTRIES must be a power of two >= 2");
   end

   logic              t_valid;
   logic [1:0]        t_cls;
   logic [CORE_W-1:0] t_owner;
   logic              t_wr_en;
   logic [IDX_W-1:0]  t_wr_idx;
   logic [1:0]        t_wr_cls;
   logic [CORE_W-1:0] t_wr_owner;

   sct_cls_e          c_cls;
   logic [CORE_W-1:0] c_owner;
   logic              c_esc;

   logic              d_active;
   logic              d_finish;
   logic [CORE_W-1:0] d_core;
   logic              accept;

   sct_table #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .CORE_W     (CORE_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_idx),
      .rd_valid(t_valid),
      .rd_cls  (t_cls),
      .rd_owner(t_owner),
      .wr_en   (t_wr_en),
      .wr_idx  (t_wr_idx),
      .wr_cls  (t_wr_cls),
      .wr_owner(t_wr_owner)
   );

   sct_classify #(
      .CORE_W(CORE_W)
   ) u_classify (
      .hit_valid(t_valid),
      .cur_cls  (t_cls),
      .cur_owner(t_owner),
      .core     (req_core),
      .write    (req_write),
      .nxt_cls  (c_cls),
      .nxt_owner(c_owner),
      .escalate (c_esc)
   );

   sct_dgctl #(
      .NUM_CORES(NUM_CORES),
      .IDX_W    (IDX_W)
   ) u_dgctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && c_esc),
      .start_core(req_core),
      .start_idx (req_idx),
      .ack       (dg_ack),
      .pend      (dg_req),
      .active    (d_active),
      .finishing (d_finish),
      .idx       (dg_idx),
      .core      (d_core)
   );

   // Hold off: same entry, a second escalation, or the closing cycle.
   assign req_busy = req_valid && d_active &&
                     ((req_idx == dg_idx) || c_esc || d_finish);
   assign accept   = req_valid && !req_busy;

   always_comb begin
      t_wr_en    = 1'b0;
      t_wr_idx   = req_idx;
      t_wr_cls   = c_cls;
      t_wr_owner = c_owner;
      if (d_finish) begin
         t_wr_en    = 1'b1;
         t_wr_idx   = dg_idx;
         t_wr_cls   = CLS_SRW;
         t_wr_owner = d_core;
      end else if (accept && !c_esc) begin
         t_wr_en = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_core  <= '0;
         rsp_idx   <= '0;
         rsp_class <= 2'b00;
         rsp_safe  <= 1'b0;
      end else if (d_finish) begin
         rsp_valid <= 1'b1;
         rsp_core  <= d_core;
         rsp_idx   <= dg_idx;
         rsp_class <= CLS_SRW;
         rsp_safe  <= cls_is_safe(CLS_SRW);
      end else if (accept && !c_esc) begin
         rsp_valid <= 1'b1;
         rsp_core  <= req_core;
         rsp_idx   <= req_idx;
         rsp_class <= c_cls;
         rsp_safe  <= cls_is_safe(c_cls);
      end else begin
         rsp_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/sct_chk.sv
module sct_chk #(
   parameter int NUM_CORES   = 4,
   parameter int NUM_ENTRIES = 16,
   localparam int CORE_W     = $clog2(NUM_CORES),
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_busy,
   input logic                 rsp_valid,
   input logic [1:0]           rsp_class,
   input logic                 rsp_safe,
   input logic [NUM_CORES-1:0] dg_req,
   input logic [IDX_W-1:0]     dg_idx,
   input logic [NUM_CORES-1:0] dg_ack
);

   // R10
   rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req_valid && !req_busy) || ($past(dg_req) != '0)));

   // R4
   unsafe_is_srw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_safe) |-> (rsp_class == 2'b10));

   // R5
   no_new_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dg_req != '0) |=> ((dg_req & ~$past(dg_req)) == '0));

   // R5
   clear_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dg_req != '0) |=> (($past(dg_req & ~dg_ack) & ~dg_req) == '0));

   // R7
   dg_idx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dg_req != '0) && ($past(dg_req) != '0)) |-> $stable(dg_idx));

   // R8
   close_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (dg_req != '0) && ((dg_req & ~dg_ack) == '0)) |-> req_busy);

endmodule

bind share_class_dir sct_chk #(
   .NUM_CORES  (NUM_CORES),
   .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_busy (req_busy),
   .rsp_valid(rsp_valid),
   .rsp_class(rsp_class),
   .rsp_safe (rsp_safe),
   .dg_req   (dg_req),
   .dg_idx   (dg_idx),
   .dg_ack   (dg_ack)
);

// File: tb/share_class_dir_tb.sv
module share_class_dir_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int NE = 16;
   localparam int CW = $clog2(NC);
   localparam int IW = $clog2(NE);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [CW-1:0] req_core = '0;
   logic [IW-1:0] req_idx = '0;
   logic          req_write = 1'b0;
   logic          req_busy;
   logic          rsp_valid;
   logic [CW-1:0] rsp_core;
   logic [IW-1:0] rsp_idx;
   logic [1:0]    rsp_class;
   logic          rsp_safe;
   logic [NC-1:0] dg_req;
   logic [IW-1:0] dg_idx;
   logic [NC-1:0] dg_ack = '0;

   int n_tests = 0;
   int n_fail  = 0;

   // bench model: 0 untracked, else class+1
   int m_state [NE];
   int m_owner [NE];

   always #(CLK_PERIOD/2) clk = ~clk;

   share_class_dir #(.NUM_CORES(NC), .NUM_ENTRIES(NE)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
      .req_idx(req_idx), .req_write(req_write), .req_busy(req_busy),
      .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_idx(rsp_idx),
      .rsp_class(rsp_class), .rsp_safe(rsp_safe), .dg_req(dg_req),
      .dg_idx(dg_idx), .dg_ack(dg_ack)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   function automatic int all_but(input int c);
      return ((1 << NC) - 1) & ~(1 << c);
   endfunction

   // expected class code after access, and escalation flag
   function automatic int exp_cls(input int st, input int own, input int c, input bit w);
      if (st == 0) return 0;
      if (st == 1) return (c == own) ? 0 : (w ? 2 : 1);
      if (st == 2) return w ? 2 : 1;
      return 2;
   endfunction

   function automatic bit exp_esc(input int st, input int own, input int c, input bit w);
      return (st == 1 && c != own && w) || (st == 2 && w);
   endfunction

   task automatic issue(input int c, input int idx, input bit w, input string tag);
      int  ec;
      bit  es;
      int  remain;
      ec = exp_cls(m_state[idx], m_owner[idx], c, w);
      es = exp_esc(m_state[idx], m_owner[idx], c, w);
      req_valid = 1'b1; req_core = CW'(c); req_idx = IW'(idx); req_write = w;
      #1;
      check(req_busy == 1'b0, {tag, " busy"}, int'(req_busy), 0);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      if (!es) begin
         check(rsp_valid && rsp_class == 2'(ec) && rsp_safe == (ec != 2) &&
               rsp_idx == IW'(idx) && rsp_core == CW'(c),
               {tag, " rsp"}, int'(rsp_class), ec);
         check(dg_req == '0, {tag, " R9 no downgrade"}, int'(dg_req), 0);
      end else begin
         remain = all_but(c);
         check(dg_req == NC'(remain) && dg_idx == IW'(idx) && !rsp_valid,
               {tag, " R5 dg start"}, int'(dg_req), remain);
         for (int k = 0; k < NC; k++) begin
            if (k != c) begin
               dg_ack = NC'(1 << k);
               @(posedge clk); @(negedge clk);
               dg_ack = '0;
               remain = remain & ~(1 << k);
               if (remain != 0)
                  check(!rsp_valid && dg_req == NC'(remain), {tag, " R5 ack step"},
                        int'(dg_req), remain);
               else
                  check(rsp_valid && rsp_class == 2'b10 && !rsp_safe &&
                        rsp_idx == IW'(idx) && rsp_core == CW'(c) && dg_req == '0,
                        {tag, " R6 completion"}, int'(rsp_class), 2);
            end
         end
      end
      if (m_state[idx] == 0) m_owner[idx] = c;
      m_state[idx] = ec + 1;
   endtask

   initial begin
      for (int e = 0; e < NE; e++) begin m_state[e] = 0; m_owner[e] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!rsp_valid && dg_req == '0, "R1 reset outputs", int'(dg_req), 0);
      rst_n = 1'b1;

      // Sweep over entries 0..7 with rotating core pairs
      for (int i = 0; i < 8; i++) begin
         int a;
         int b;
         a = i % NC;
         b = (i + 1 + i / NC) % NC;
         if (i % 2 == 0) begin
            issue(a, i, 1'b0, "R1 first access");
            issue(a, i, 1'b1, "R2 owner write");
            issue(a, i, 1'b0, "R2 owner read");
            issue(b, i, 1'b0, "R3 other read");
            issue(b, i, 1'b0, "R3 sro read");
            issue(a, i, 1'b0, "R3 sro owner read");
            issue(a, i, 1'b1, "R4 sro write");
         end else begin
            issue(a, i, 1'b1, "R1 first write");
            issue(b, i, 1'b1, "R4 other write");
         end
         for (int c = 0; c < NC; c++) begin
            issue(c, i, 1'b0, "R9 srw read");
            issue(c, i, 1'b1, "R9 srw write");
         end
      end

      // Concurrency on entries 8..12
      issue(0, 8, 1'b1, "R1 setup8");
      issue(1, 9, 1'b0, "R1 setup9");
      issue(2, 9, 1'b0, "R3 setup9");
      req_valid = 1'b1; req_core = 2'd3; req_idx = 4'd8; req_write = 1'b1;
      @(posedge clk); @(negedge clk);
      check(dg_req == 4'b0111 && dg_idx == 4'd8 && !rsp_valid, "R5 dg open",
            int'(dg_req), 7);
      // same entry + ack from the requester (not pending)
      req_core = 2'd1; req_write = 1'b0; dg_ack = 4'b1000;
      #1;
      check(req_busy, "R7 same entry busy", int'(req_busy), 1);
      @(posedge clk); @(negedge clk);
      check(dg_req == 4'b0111 && !rsp_valid, "R5 stray ack ignored", int'(dg_req), 7);
      // second escalation while open + ack core0
      req_core = 2'd0; req_idx = 4'd9; req_write = 1'b1; dg_ack = 4'b0001;
      #1;
      check(req_busy, "R7 second escalation busy", int'(req_busy), 1);
      @(posedge clk); @(negedge clk);
      check(dg_req == 4'b0110 && !rsp_valid, "R7 busy req dropped", int'(dg_req), 6);
      // unrelated fresh entry goes through
      req_core = 2'd2; req_idx = 4'd10; req_write = 1'b0; dg_ack = '0;
      #1;
      check(!req_busy, "R7 unrelated accepted", int'(req_busy), 0);
      @(posedge clk); @(negedge clk);
      check(rsp_valid && rsp_idx == 4'd10 && rsp_class == 2'b00 && rsp_safe,
            "R10 rsp during downgrade", int'(rsp_idx), 10);
      m_state[10] = 1; m_owner[10] = 2;
      req_idx = 4'd11; dg_ack = 4'b0010;
      #1;
      check(!req_busy, "R7 non-final ack no stall", int'(req_busy), 0);
      @(posedge clk); @(negedge clk);
      check(rsp_valid && rsp_idx == 4'd11 && dg_req == 4'b0100, "R10 rsp idx11",
            int'(rsp_idx), 11);
      m_state[11] = 1; m_owner[11] = 2;
      // final ack with a fresh request
      req_core = 2'd0; req_idx = 4'd12; dg_ack = 4'b0100;
      #1;
      check(req_busy, "R8 final ack stalls", int'(req_busy), 1);
      @(posedge clk); @(negedge clk);
      dg_ack = '0;
      check(rsp_valid && rsp_idx == 4'd8 && rsp_core == 2'd3 && rsp_class == 2'b10 &&
            !rsp_safe && dg_req == '0, "R6 completion concurrent", int'(rsp_idx), 8);
      m_state[8] = 3;
      #1;
      check(!req_busy, "R8 held req now taken", int'(req_busy), 0);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_idx == 4'd12 && rsp_core == 2'd0 && rsp_class == 2'b00,
            "R10 held rsp", int'(rsp_idx), 12);
      m_state[12] = 1; m_owner[12] = 0;
      issue(1, 8, 1'b0, "R9 after concurrent");
      issue(0, 9, 1'b1, "R4 deferred escalation");
      issue(3, 10, 1'b0, "R3 idx10 other read");

      @(negedge clk);
      summary();
   end

endmodule